// File: doc/BRIEF.md
# Key-Locked GPIO Port Controller

This block is one memory-mapped general-purpose I/O port with up to 32 pins. Software reaches it over a plain single-cycle register bus: an address, a write strobe, write data and combinational read data. Every pin owns an output latch and a two-bit drive mode. From these the block produces the pad's output value and output enable. A pin can be a pure input, a push-pull output, a sink-only output that pulls low or floats, or a source-only output that pulls high or floats.

The drive modes decide which pins may drive the board, so a key-protected lock guards them. A mode write lands only while the lock is armed. The lock is armed by writing one magic 16-bit key and disarmed by writing zero. The output latches stay writable at all times. Pad levels come back through a two-flop synchroniser and can be read as one word.

Top module: `keylock_gpio_port`

## Requirements
- R1: After a synchronous active-low reset, all mode bits and output latches are 0 and the lock is inactive. Every pad_oe bit and every pad_out bit is therefore 0.
- R2: The lock register is at offset 0x00 and its key field is in bits 15:0. Writing the key 0xD42F arms the lock from the next cycle. Bits 31:16 of the written word do not matter.
- R3: Writing key 0x0000 to the lock register disarms the lock.
- R4: Writing any other key value to the lock register leaves the lock state unchanged, whether the lock is armed or not.
- R5: While the lock is inactive, writes to offsets 0x08, 0x0C, 0x50, 0x54 and 0x58 leave both mode registers unchanged.
- R6: While the lock is armed, mode bits are written as follows. A write to 0x08 loads the high mode bits and a write to 0x0C loads the low mode bits. 0x54 sets the low mode bits written as 1. 0x50 clears the high mode bits written as 1 and 0x58 clears the low mode bits written as 1. Bits written as 0 are left unchanged. Reads of 0x08 and 0x0C return the high and low mode bits.
- R7: Without regard to the lock, a write to 0x14 sets and a write to 0x18 clears the output-latch bits written as 1. Bits written as 0 are left unchanged.
- R8: Per pin, {high mode, low mode} gives the pad behaviour. 00: enable 0 and value 0. 01: enable 1 and value equal to the latch. 10: value 0, enabled only when the latch is 0. 11: value 1, enabled only when the latch is 1.
- R9: A read of 0x04 returns the pad input levels. A change on pad_in shows up after the second rising clock edge that follows it, and not after the first.
- R10: Bit positions at or above PIN_COUNT read as 0 from every register, and writing 1 to them has no effect.
- R11: Reads from offsets other than 0x00, 0x04, 0x08 and 0x0C return 0. Writes to offsets outside the defined set change no state.
- R12: A read of the lock register returns the lock state in bit 31, and all other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| pad_in | input | PIN_COUNT | Pad levels, asynchronous to clk |
| pad_out | output | PIN_COUNT | Value offered to each pad |
| pad_oe | output | PIN_COUNT | Output enable of each pad |

## Verification
The assertions assume two things about the bus. A write is a single cycle of bus_we with the address and data stable around the rising edge. Only one register is addressed per cycle. The bench drives every bus signal on the falling edge and releases bus_we after one cycle, so each write meets this. Since pad_in is asynchronous, no assertion ties it to readback timing. The bench changes pad_in on the falling edge and checks the level word one edge and two edges later.

// File: rtl/gpio_port_pkg.sv
// Package: shared offsets, lock keys, drive-mode encoding and the bus
// decode result type for the key-locked GPIO port.
// Assumes byte offsets fit in REG_ADDR_W bits and data is 32 bits wide.
package gpio_port_pkg;

    localparam int REG_ADDR_W  = 8;
    localparam int REG_DATA_W  = 32;
    localparam int KEY_W       = 16;
    localparam int MAX_PINS    = 32;
    localparam int LOCK_STAT_B = 31;

    localparam logic [REG_ADDR_W-1:0] OFS_LOCK        = 8'h00;
    localparam logic [REG_ADDR_W-1:0] OFS_PIN_LEVEL   = 8'h04;
    localparam logic [REG_ADDR_W-1:0] OFS_MODE_HI     = 8'h08;
    localparam logic [REG_ADDR_W-1:0] OFS_MODE_LO     = 8'h0C;
    localparam logic [REG_ADDR_W-1:0] OFS_OUT_SET     = 8'h14;
    localparam logic [REG_ADDR_W-1:0] OFS_OUT_CLR     = 8'h18;
    localparam logic [REG_ADDR_W-1:0] OFS_MODE_HI_CLR = 8'h50;
    localparam logic [REG_ADDR_W-1:0] OFS_MODE_LO_SET = 8'h54;
    localparam logic [REG_ADDR_W-1:0] OFS_MODE_LO_CLR = 8'h58;

    localparam logic [KEY_W-1:0] KEY_ARM    = 16'hD42F;
    localparam logic [KEY_W-1:0] KEY_DISARM = 16'h0000;

    // {high mode bit, low mode bit} per pin
    typedef enum logic [1:0] {
        DRV_INPUT    = 2'b00,
        DRV_PUSHPULL = 2'b01,
        DRV_SINK     = 2'b10,
        DRV_SOURCE   = 2'b11
    } drive_mode_e;

    typedef enum logic [2:0] {
        RD_NONE,
        RD_LOCK,
        RD_LEVEL,
        RD_MODE_HI,
        RD_MODE_LO
    } rd_sel_e;

    typedef struct packed {
        logic lock;
        logic mode_hi;
        logic mode_lo;
        logic out_set;
        logic out_clr;
        logic mode_hi_clr;
        logic mode_lo_set;
        logic mode_lo_clr;
    } wr_strobe_t;

endpackage

// File: rtl/gpio_bus_decode.sv
// Module: gpio_bus_decode
// Turns the bus offset and write strobe into one-hot register write
// strobes and a read-source select. Purely combinational.
// Assumes: offsets outside the package list select nothing.
module gpio_bus_decode
    import gpio_port_pkg::*;
(
    input  logic [REG_ADDR_W-1:0] addr,
    input  logic                  we,
    output wr_strobe_t            wr,
    output rd_sel_e               rd_sel
);

    // Write strobe per register offset
    always_comb begin
        wr             = '0;
        wr.lock        = we && (addr == OFS_LOCK);
        wr.mode_hi     = we && (addr == OFS_MODE_HI);
        wr.mode_lo     = we && (addr == OFS_MODE_LO);
        wr.out_set     = we && (addr == OFS_OUT_SET);
        wr.out_clr     = we && (addr == OFS_OUT_CLR);
        wr.mode_hi_clr = we && (addr == OFS_MODE_HI_CLR);
        wr.mode_lo_set = we && (addr == OFS_MODE_LO_SET);
        wr.mode_lo_clr = we && (addr == OFS_MODE_LO_CLR);
    end

    // Read source for the addressed offset
    always_comb begin
        unique case (addr)
            OFS_LOCK:      rd_sel = RD_LOCK;
            OFS_PIN_LEVEL: rd_sel = RD_LEVEL;
            OFS_MODE_HI:   rd_sel = RD_MODE_HI;
            OFS_MODE_LO:   rd_sel = RD_MODE_LO;
            default:       rd_sel = RD_NONE;
        endcase
    end

endmodule

// File: rtl/gpio_key_lock.sv
// Module: gpio_key_lock
// Holds the lock flag that gates mode writes. The arm key sets the flag,
// the disarm key clears it, and any other key leaves it alone.
// Assumes: wr_lock is a one-cycle strobe with key stable at the edge.
module gpio_key_lock
    import gpio_port_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_lock,
    input  logic [KEY_W-1:0] key,
    output logic             lock_active
);

    // Lock flag update on key writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_active <= 1'b0;
        end else if (wr_lock) begin
            if (key == KEY_ARM) begin
                lock_active <= 1'b1;
            end else if (key == KEY_DISARM) begin
                lock_active <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/gpio_pin_state.sv
// Module: gpio_pin_state
// Per-pin state: the output latch plus the high and low drive-mode bits.
// Mode writes are qualified by lock_active, and latch writes are not.
// Assumes: at most one strobe is active in a cycle.
module gpio_pin_state #(
    parameter int PINS = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            lock_active,
    input  logic            wr_mode_hi,
    input  logic            wr_mode_lo,
    input  logic            wr_mode_hi_clr,
    input  logic            wr_mode_lo_set,
    input  logic            wr_mode_lo_clr,
    input  logic            wr_out_set,
    input  logic            wr_out_clr,
    input  logic [PINS-1:0] wdata,
    output logic [PINS-1:0] mode_hi_q,
    output logic [PINS-1:0] mode_lo_q,
    output logic [PINS-1:0] latch_q
);

    logic mode_wr_ok;
    assign mode_wr_ok = lock_active;

    // High mode bits: direct load or clear-by-mask under the lock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_hi_q <= '0;
        end else if (mode_wr_ok && wr_mode_hi) begin
            mode_hi_q <= wdata;
        end else if (mode_wr_ok && wr_mode_hi_clr) begin
            mode_hi_q <= mode_hi_q & ~wdata;
        end
    end

    // Low mode bits: direct load, set- or clear-by-mask under the lock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_lo_q <= '0;
        end else if (mode_wr_ok && wr_mode_lo) begin
            mode_lo_q <= wdata;
        end else if (mode_wr_ok && wr_mode_lo_set) begin
            mode_lo_q <= mode_lo_q | wdata;
        end else if (mode_wr_ok && wr_mode_lo_clr) begin
            mode_lo_q <= mode_lo_q & ~wdata;
        end
    end

    // Output latch: set- or clear-by-mask, never gated
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '0;
        end else if (wr_out_set) begin
            latch_q <= latch_q | wdata;
        end else if (wr_out_clr) begin
            latch_q <= latch_q & ~wdata;
        end
    end

endmodule

// File: rtl/gpio_pad_ctrl.sv
// Module: gpio_pad_ctrl
// Maps each pin's drive mode and latch to a pad value and output enable.
// Purely combinational, with one identical slice per pin.
// Assumes: the pad cell floats whenever its enable is low.
module gpio_pad_ctrl
    import gpio_port_pkg::*;
#(
    parameter int PINS = 32
) (
    input  logic [PINS-1:0] mode_hi,
    input  logic [PINS-1:0] mode_lo,
    input  logic [PINS-1:0] latch,
    output logic [PINS-1:0] pad_out,
    output logic [PINS-1:0] pad_oe
);

    for (genvar p = 0; p < PINS; p++) begin : g_pin
        drive_mode_e mode;
        assign mode = drive_mode_e'({mode_hi[p], mode_lo[p]});

        // Drive table for one pin
        always_comb begin
            unique case (mode)
                DRV_PUSHPULL: begin pad_out[p] = latch[p]; pad_oe[p] = 1'b1;      end
                DRV_SINK:     begin pad_out[p] = 1'b0;     pad_oe[p] = ~latch[p]; end
                DRV_SOURCE:   begin pad_out[p] = 1'b1;     pad_oe[p] = latch[p];  end
                default:      begin pad_out[p] = 1'b0;     pad_oe[p] = 1'b0;      end
            endcase
        end
    end

endmodule

// File: rtl/gpio_in_sync.sv
// Module: gpio_in_sync
// Brings asynchronous pad levels into the clock domain through a chain
// of STAGES flops per pin.
// Assumes: STAGES >= 2. Pads need no glitch filtering.
module gpio_in_sync #(
    parameter int PINS   = 32,
    parameter int STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] async_in,
    output logic [PINS-1:0] sync_out
);

    logic [PINS-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        // One synchroniser rank
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage_q[s] <= '0;
            end else begin
                stage_q[s] <= (s == 0) ? async_in : stage_q[(s == 0) ? 0 : s-1];
            end
        end
    end

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/keylock_gpio_port.sv
// Module: keylock_gpio_port (top)
// GPIO port with per-pin latch and two-bit drive mode. A key lock guards
// the mode registers. Reads are combinational from bus_addr.
// Assumes: single-cycle writes, PIN_COUNT between 1 and 32.
module keylock_gpio_port
    import gpio_port_pkg::*;
#(
    parameter int PIN_COUNT   = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [REG_ADDR_W-1:0] bus_addr,
    input  logic                  bus_we,
    input  logic [REG_DATA_W-1:0] bus_wdata,
    output logic [REG_DATA_W-1:0] bus_rdata,
    input  logic [PIN_COUNT-1:0]  pad_in,
    output logic [PIN_COUNT-1:0]  pad_out,
    output logic [PIN_COUNT-1:0]  pad_oe
);

    wr_strobe_t           wr;
    rd_sel_e              rd_sel;
    logic                 lock_active;
    logic [PIN_COUNT-1:0] mode_hi_q;
    logic [PIN_COUNT-1:0] mode_lo_q;
    logic [PIN_COUNT-1:0] latch_q;
    logic [PIN_COUNT-1:0] level_sync;

    gpio_bus_decode u_decode (
        .addr   (bus_addr),
        .we     (bus_we),
        .wr     (wr),
        .rd_sel (rd_sel)
    );

    gpio_key_lock u_lock (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_lock     (wr.lock),
        .key         (bus_wdata[KEY_W-1:0]),
        .lock_active (lock_active)
    );

    gpio_pin_state #(.PINS(PIN_COUNT)) u_state (
        .clk            (clk),
        .rst_n          (rst_n),
        .lock_active    (lock_active),
        .wr_mode_hi     (wr.mode_hi),
        .wr_mode_lo     (wr.mode_lo),
        .wr_mode_hi_clr (wr.mode_hi_clr),
        .wr_mode_lo_set (wr.mode_lo_set),
        .wr_mode_lo_clr (wr.mode_lo_clr),
        .wr_out_set     (wr.out_set),
        .wr_out_clr     (wr.out_clr),
        .wdata          (bus_wdata[PIN_COUNT-1:0]),
        .mode_hi_q      (mode_hi_q),
        .mode_lo_q      (mode_lo_q),
        .latch_q        (latch_q)
    );

    gpio_pad_ctrl #(.PINS(PIN_COUNT)) u_pad (
        .mode_hi (mode_hi_q),
        .mode_lo (mode_lo_q),
        .latch   (latch_q),
        .pad_out (pad_out),
        .pad_oe  (pad_oe)
    );

    gpio_in_sync #(.PINS(PIN_COUNT), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (level_sync)
    );

    // Read mux: zero-extend pin vectors, place lock flag at its bit
    always_comb begin
        bus_rdata = '0;
        unique case (rd_sel)
            RD_LOCK:    bus_rdata[LOCK_STAT_B]    = lock_active;
            RD_LEVEL:   bus_rdata[PIN_COUNT-1:0]  = level_sync;
            RD_MODE_HI: bus_rdata[PIN_COUNT-1:0]  = mode_hi_q;
            RD_MODE_LO: bus_rdata[PIN_COUNT-1:0]  = mode_lo_q;
            default:    bus_rdata                 = '0;
        endcase
    end

endmodule

// File: rtl/keylock_gpio_port_chk.sv
// Module: keylock_gpio_port_chk
// Property checker bound into keylock_gpio_port. It watches the bus, the
// lock flag, the pin state and the pad outputs.
// Assumes: single-cycle writes with stable address and data at the edge.
module keylock_gpio_port_chk
    import gpio_port_pkg::*;
#(
    parameter int PIN_COUNT = 32
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [REG_ADDR_W-1:0] bus_addr,
    input logic                  bus_we,
    input logic [REG_DATA_W-1:0] bus_wdata,
    input logic                  lock_active,
    input logic [PIN_COUNT-1:0]  mode_hi_q,
    input logic [PIN_COUNT-1:0]  mode_lo_q,
    input logic [PIN_COUNT-1:0]  latch_q,
    input logic [PIN_COUNT-1:0]  pad_out,
    input logic [PIN_COUNT-1:0]  pad_oe
);

    logic lock_wr;
    logic out_set_wr;
    assign lock_wr    = bus_we && (bus_addr == OFS_LOCK);
    assign out_set_wr = bus_we && (bus_addr == OFS_OUT_SET);

    AST_LOCK_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        lock_wr && (bus_wdata[KEY_W-1:0] == KEY_ARM) |=> lock_active); // R2

    AST_LOCK_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        lock_wr && (bus_wdata[KEY_W-1:0] == KEY_DISARM) |=> !lock_active); // R3

    AST_LOCK_OTHER_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        lock_wr && (bus_wdata[KEY_W-1:0] != KEY_ARM) && (bus_wdata[KEY_W-1:0] != KEY_DISARM)
        |=> $stable(lock_active)); // R4

    AST_MODE_FROZEN_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_active |=> $stable(mode_hi_q) && $stable(mode_lo_q)); // R5

    AST_OUT_SET_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        out_set_wr |=> ((latch_q & $past(bus_wdata[PIN_COUNT-1:0])) == $past(bus_wdata[PIN_COUNT-1:0]))); // R7

    AST_INPUT_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
        ((~mode_hi_q & ~mode_lo_q) & pad_oe) == '0); // R8

    AST_PUSHPULL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        ((~mode_hi_q & mode_lo_q) & ((pad_out ^ latch_q) | ~pad_oe)) == '0); // R8

    AST_SINK_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_hi_q & ~mode_lo_q) & pad_oe & (pad_out | latch_q)) == '0); // R8

endmodule

bind keylock_gpio_port keylock_gpio_port_chk #(.PIN_COUNT(PIN_COUNT)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_we      (bus_we),
    .bus_wdata   (bus_wdata),
    .lock_active (lock_active),
    .mode_hi_q   (mode_hi_q),
    .mode_lo_q   (mode_lo_q),
    .latch_q     (latch_q),
    .pad_out     (pad_out),
    .pad_oe      (pad_oe)
);

// File: tb/keylock_gpio_port_tb.sv
// Bench: 8-pin configuration with exhaustive latch and pad-level sweeps.
// Expected pad values are computed per bit from the drive table.
module keylock_gpio_port_tb;

    localparam int NP = 8;
    localparam logic [31:0] PMASK = 32'h0000_00FF;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] pad_out;
    logic [NP-1:0] pad_oe;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    keylock_gpio_port #(.PIN_COUNT(NP)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic logic [2*NP-1:0] pads_exp(input logic [NP-1:0] m1,
                                                 input logic [NP-1:0] m0,
                                                 input logic [NP-1:0] l);
        logic [NP-1:0] eo, ee;
        for (int i = 0; i < NP; i++) begin
            case ({m1[i], m0[i]})
                2'b01:   begin eo[i] = l[i]; ee[i] = 1'b1;  end
                2'b10:   begin eo[i] = 1'b0; ee[i] = ~l[i]; end
                2'b11:   begin eo[i] = 1'b1; ee[i] = l[i];  end
                default: begin eo[i] = 1'b0; ee[i] = 1'b0;  end
            endcase
        end
        return {ee, eo};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        logic [NP-1:0] m1s [5];
        logic [NP-1:0] m0s [5];
        m1s[0] = 8'h00; m0s[0] = 8'h00;
        m1s[1] = 8'h00; m0s[1] = 8'hFF;
        m1s[2] = 8'hFF; m0s[2] = 8'h00;
        m1s[3] = 8'hFF; m0s[3] = 8'hFF;
        m1s[4] = 8'h3C; m0s[4] = 8'h5A;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(8'h00, r); check(r, 32'h0, "R1 lock");
        rd(8'h08, r); check(r, 32'h0, "R1 mode_hi");
        rd(8'h0C, r); check(r, 32'h0, "R1 mode_lo");
        check({24'h0, pad_oe}, 32'h0, "R1 pad_oe");
        check({24'h0, pad_out}, 32'h0, "R1 pad_out");

        // R5 mode writes ignored while unlocked
        wr(8'h08, 32'hFF); wr(8'h0C, 32'hFF); wr(8'h54, 32'hFF);
        rd(8'h08, r); check(r, 32'h0, "R5 mode_hi unlocked");
        rd(8'h0C, r); check(r, 32'h0, "R5 mode_lo unlocked");
        check({24'h0, pad_oe}, 32'h0, "R5 pad_oe unlocked");

        // R4 wrong key, R2 arm key with junk upper bits, R12 readback
        wr(8'h00, 32'h0000_1234); rd(8'h00, r); check(r, 32'h0, "R4 wrong key idle");
        wr(8'h00, 32'hFFFF_D42F); rd(8'h00, r); check(r, 32'h8000_0000, "R2 R12 armed");
        wr(8'h00, 32'h0000_D42E); rd(8'h00, r); check(r, 32'h8000_0000, "R4 wrong key armed");

        // R6 mode writes under lock, R10 upper bits dropped
        wr(8'h0C, 32'hFFFF_FFFF); rd(8'h0C, r); check(r, 32'hFF, "R10 R6 mode_lo load");
        wr(8'h58, 32'h0F); rd(8'h0C, r); check(r, 32'hF0, "R6 mode_lo clear");
        wr(8'h54, 32'h03); rd(8'h0C, r); check(r, 32'hF3, "R6 mode_lo set");
        wr(8'h08, 32'h3C); rd(8'h08, r); check(r, 32'h3C, "R6 mode_hi load");
        wr(8'h50, 32'h0C); rd(8'h08, r); check(r, 32'h30, "R6 mode_hi clear");

        // R8 pad table sweep over mode patterns and all latch values
        for (int p = 0; p < 5; p++) begin
            wr(8'h08, {24'h0, m1s[p]});
            wr(8'h0C, {24'h0, m0s[p]});
            for (int v = 0; v < 256; v++) begin
                wr(8'h18, 32'hFF);
                wr(8'h14, 32'(v));
                #1;
                check({16'h0, pad_oe, pad_out},
                      {16'h0, pads_exp(m1s[p], m0s[p], 8'(v))}, "R8 pad table");
            end
        end

        // R3 disarm, then R5 gated writes including clear aliases
        wr(8'h08, 32'h00); wr(8'h0C, 32'hFF);
        wr(8'h00, 32'hABCD_0000); rd(8'h00, r); check(r, 32'h0, "R3 disarm");
        wr(8'h0C, 32'h00); wr(8'h58, 32'hFF); wr(8'h08, 32'hFF);
        rd(8'h0C, r); check(r, 32'hFF, "R5 mode_lo gated");
        rd(8'h08, r); check(r, 32'h00, "R5 mode_hi gated");

        // R7 latch writes without the lock
        wr(8'h18, 32'hFF); wr(8'h14, 32'h96);
        #1; check({24'h0, pad_out}, 32'h96, "R7 set unlocked");
        wr(8'h18, 32'h06);
        #1; check({24'h0, pad_out}, 32'h90, "R7 clear unlocked");
        wr(8'h14, 32'h00);
        #1; check({24'h0, pad_out}, 32'h90, "R7 zero bits no effect");

        // R11 undefined offsets: read 0, writes change nothing
        wr(8'h10, 32'hFFFF_FFFF); wr(8'h5C, 32'hFFFF_FFFF); wr(8'h4C, 32'h0);
        #1; check({16'h0, pad_oe, pad_out}, 32'h0000_FF90, "R11 pads unchanged");
        rd(8'h0C, r); check(r, 32'hFF, "R11 mode_lo unchanged");
        rd(8'h00, r); check(r, 32'h0, "R11 lock unchanged");
        rd(8'h10, r); check(r, 32'h0, "R11 read 0x10");
        rd(8'h14, r); check(r, 32'h0, "R11 read 0x14");
        rd(8'h58, r); check(r, 32'h0, "R11 read 0x58");

        // R9 synchroniser latency sweep
        pad_in = '0;
        repeat (3) @(negedge clk);
        for (int v = 1; v < 256; v++) begin
            pad_in = NP'(v);
            @(negedge clk);
            rd(8'h04, r); check(r, 32'(v - 1) & PMASK, "R9 one edge old value");
            @(negedge clk);
            rd(8'h04, r); check(r, 32'(v), "R9 two edges new value");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule